// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by means of a down-counter that software must reload at regular intervals. A strobe input marks each cycle of the watchdog clock. A fixed divide-by-four prescaler turns those strobes into counter steps. Software reaches the block through a small word-addressed register bus. It can set the time-out constant, the window threshold and the warning threshold. It can arm the watchdog, and it reloads the counter by writing two key bytes to the feed register, one straight after the other.

The block treats three events as a fault. The first is a counter that steps while it already holds zero. The second is a broken feed sequence. The third is a feed in windowed operation while the count is still above the window threshold. On a fault the block responds in one of two ways, chosen by the response-mode bit. It can pulse a reset request and return its registers to their defaults, keeping a sticky flag that records the watchdog reset. Or it can raise an interrupt and drop the enable. A separate warning interrupt fires when the count reaches a chosen value. A control bit drives an output that selects between two oscillator sources for the watchdog clock.

Register word addresses: 0 control, 1 time-out constant, 2 feed, 3 current count (read only), 4 warning value, 5 window value. Control bits:

| Bit | Meaning | Write behaviour |
|-----|---------|-----------------|
| 0 | enable | set only |
| 1 | response mode, 1 = reset request, 0 = interrupt | read/write |
| 2 | watchdog-reset flag | writing 0 clears it |
| 3 | warning flag | writing 1 clears it |
| 4 | clock select | read/write |
| 5 | fault interrupt flag | writing 1 clears it |

Top module: `win_watchdog`

## Requirements
- R1: After power-on reset the registers read as follows: control 0, time-out constant 0xFF, count 0xFF, warning value 0, window value 0xFFFFFF. All outputs are low.
- R2: A time-out constant write below 0xFF stores 0xFF. Any other value is stored as written, over its full 24 bits.
- R3: While enabled, the count drops by one on every fourth watchdog clock strobe. A valid feed reloads the count from the time-out constant and restarts the prescaler. A valid feed is a write of 0xAA to address 2 followed by a write of 0x55 to address 2 as the very next bus access.
- R4: Once set, the enable bit (control bit 0) cannot be cleared by a bus write.
- R5: In reset mode (control bit 1 = 1), a fault pulses `wdt_reset_req` high for exactly one cycle. The same fault returns every register to its R1 value, except that control bit 2 reads 1.
- R6: In interrupt mode, a fault sets control bit 5 and clears the enable. `wdt_irq` follows bit 5, and writing 1 to bit 5 clears it.
- R7: While enabled, a broken feed sequence is a fault. This covers any bus access other than a 0x55 feed write directly after a 0xAA feed write. It also covers a feed-register write of any value other than 0xAA when no sequence is open.
- R8: While enabled, a feed completed with the count above the window value is a fault and does not reload. A feed with the count at or below the window value reloads.
- R9: `warn_irq` (control bit 3) is set when a step brings the count to the warning value. Writing 1 to bit 3 clears it.
- R10: Control bit 2 is cleared only by power-on reset or by a control write with bit 2 = 0. A control write with bit 2 = 1 leaves it set.
- R11: `clk_sel` follows control bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, registered, valid the cycle after the read strobe |
| wd_tick | input | 1 | One pulse per watchdog clock cycle |
| clk_sel | output | 1 | Watchdog clock source select |
| wdt_reset_req | output | 1 | One-cycle reset request on a fault in reset mode |
| wdt_irq | output | 1 | Fault interrupt in interrupt mode |
| warn_irq | output | 1 | Early-warning interrupt |

## Verification
A wrong count or a prescaler that is off by one first shows in the read-back count. It then shows as a warning or fault that arrives some strobes early or late. The bench pins these down to the exact strobe, one strobe before and at the expected point. A feed state machine left armed, or a window compare with the wrong sense, shows at once as a spurious or missing `wdt_irq` on the access that completes or breaks the sequence. Lost or wrongly reset register state after a reset-mode fault appears on the first control and constant read-back that follows.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_TCON = 3'd1,
    A_FEED = 3'd2,
    A_TVAL = 3'd3,
    A_WARN = 3'd4,
    A_WIN  = 3'd5
  } wdt_addr_e;

  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;

  localparam int C_EN   = 0;
  localparam int C_MODE = 1;
  localparam int C_FLAG = 2;
  localparam int C_WARN = 3;
  localparam int C_CSEL = 4;
  localparam int C_IRQ  = 5;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic step
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] cnt;

  assign step = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R3: steps can never come on two cycles in a row when the divider is above one
  p_step_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (DIV > 1 && step && !clr) |=> !step);
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       access,
  input  logic       feed_wr,
  input  logic [7:0] key,
  output logic       feed_ok,
  output logic       feed_bad
);
  logic armed;

  always_comb begin
    feed_ok  = 1'b0;
    feed_bad = 1'b0;
    if (access) begin
      if (armed) begin
        if (feed_wr && key == FEED_KEY2) feed_ok = 1'b1;
        else                              feed_bad = 1'b1;
      end else if (feed_wr && key != FEED_KEY1) begin
        feed_bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed <= 1'b0;
    end else if (access) begin
      armed <= !armed && feed_wr && key == FEED_KEY1;
    end
  end

  // R7: a completed feed must follow an opening key write
  p_ok_needs_arm_r7: assert property (@(posedge clk) disable iff (rst)
    feed_ok |-> armed);
  // R7: any access closes an open sequence
  p_access_disarms_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && access) |=> !armed);
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W  = 24,
  parameter int MIN_TC = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] warn_val,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             warn_hit
);
  localparam logic [CNT_W-1:0] TC_MIN = CNT_W'(MIN_TC);

  logic [CNT_W-1:0] next_dec;

  assign next_dec = count - 1'b1;
  assign expire   = step && !load && (count == '0);
  assign warn_hit = step && !load && (count != '0) && (next_dec == warn_val);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= TC_MIN;
    end else if (load) begin
      count <= load_val;
    end else if (step && count != '0) begin
      count <= next_dec;
    end
  end

  // R3: each step lowers a non-zero count by exactly one
  p_step_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clr && count != '0) |=> count == CNT_W'($past(count) - 1'b1));
  // R3: without a step or load the count holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!step && !load && !clr) |=> $stable(count));
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DIV    = 4,
  parameter int MIN_TC = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              wd_tick,
  output logic              clk_sel,
  output logic              wdt_reset_req,
  output logic              wdt_irq,
  output logic              warn_irq
);
  localparam logic [CNT_W-1:0] TC_MIN  = CNT_W'(MIN_TC);
  localparam logic [CNT_W-1:0] WIN_MAX = '1;

  logic             en_q, mode_q, flag_q, warnf_q, csel_q, irqf_q, rreq_q;
  logic [CNT_W-1:0] tc_q, warn_q, win_q, rdata_q;
  logic [CNT_W-1:0] count;
  logic             step, expire, warn_hit;
  logic             feed_ok, feed_bad, win_err, reload, fault, sclr;
  logic             access, feed_wr;

  assign access  = bus_wr || bus_rd;
  assign feed_wr = bus_wr && (bus_addr == A_FEED);
  assign win_err = en_q && feed_ok && (count > win_q);
  assign reload  = feed_ok && !win_err;
  assign fault   = en_q && (expire || feed_bad || win_err);
  assign sclr    = fault && mode_q;

  wdt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clr(sclr || reload), .run(en_q),
    .tick(wd_tick), .step(step)
  );

  wdt_feed_seq u_feed (
    .clk(clk), .rst(rst), .clr(sclr), .access(access), .feed_wr(feed_wr),
    .key(bus_wdata[7:0]), .feed_ok(feed_ok), .feed_bad(feed_bad)
  );

  wdt_downcount #(.CNT_W(CNT_W), .MIN_TC(MIN_TC)) u_cnt (
    .clk(clk), .rst(rst), .clr(sclr), .load(reload), .load_val(tc_q),
    .step(step), .warn_val(warn_q), .count(count), .expire(expire),
    .warn_hit(warn_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || sclr) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      warnf_q <= 1'b0;
      csel_q  <= 1'b0;
      irqf_q  <= 1'b0;
      tc_q    <= TC_MIN;
      warn_q  <= '0;
      win_q   <= WIN_MAX;
      flag_q  <= !rst;
      rreq_q  <= !rst;
    end else begin
      rreq_q <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: begin
            en_q   <= en_q | bus_wdata[C_EN];
            mode_q <= bus_wdata[C_MODE];
            csel_q <= bus_wdata[C_CSEL];
            if (!bus_wdata[C_FLAG]) flag_q  <= 1'b0;
            if (bus_wdata[C_WARN])  warnf_q <= 1'b0;
            if (bus_wdata[C_IRQ])   irqf_q  <= 1'b0;
          end
          A_TCON:  tc_q   <= (bus_wdata < TC_MIN) ? TC_MIN : bus_wdata;
          A_WARN:  warn_q <= bus_wdata;
          A_WIN:   win_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (warn_hit) warnf_q <= 1'b1;
      if (fault) begin
        irqf_q <= 1'b1;
        en_q   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  rdata_q <= CNT_W'({irqf_q, csel_q, warnf_q, flag_q, mode_q, en_q});
        A_TCON:  rdata_q <= tc_q;
        A_TVAL:  rdata_q <= count;
        A_WARN:  rdata_q <= warn_q;
        A_WIN:   rdata_q <= win_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata     = rdata_q;
  assign clk_sel       = csel_q;
  assign wdt_reset_req = rreq_q;
  assign wdt_irq       = irqf_q;
  assign warn_irq      = warnf_q;

  // R4: the enable only falls through a fault
  p_en_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (en_q && !fault) |=> en_q);
  // R5: the reset request is a single-cycle pulse
  p_rstreq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |=> !wdt_reset_req);
  // R5: a reset request always comes with the cause flag set and the enable low
  p_flag_on_rstreq_r5: assert property (@(posedge clk) disable iff (rst)
    wdt_reset_req |-> (flag_q && !en_q));
  // R2: the stored constant never drops below the floor
  p_tc_floor_r2: assert property (@(posedge clk) disable iff (rst)
    tc_q >= TC_MIN);
  // R6: a newly raised fault interrupt leaves the watchdog disabled
  p_irq_clears_en_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irqf_q) |-> !en_q);
endmodule

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, wd_tick = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic        clk_sel, wdt_reset_req, wdt_irq, warn_irq;

  int n_run = 0;
  int n_fail = 0;
  logic [23:0] rv;

  always #5 clk = ~clk;

  win_watchdog u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_tick(wd_tick),
    .clk_sel(clk_sel), .wdt_reset_req(wdt_reset_req), .wdt_irq(wdt_irq),
    .warn_irq(warn_irq)
  );

  typedef struct packed {
    logic [2:0]  a;
    logic [23:0] d;
    logic [23:0] e;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 24'h000010, 24'h0000FF},
    '{3'd1, 24'h0000FE, 24'h0000FF},
    '{3'd1, 24'h000100, 24'h000100},
    '{3'd1, 24'hABCDEF, 24'hABCDEF},
    '{3'd1, 24'hFFFFFF, 24'hFFFFFF},
    '{3'd4, 24'h000055, 24'h000055},
    '{3'd5, 24'h000800, 24'h000800},
    '{3'd5, 24'hFFFFFF, 24'hFFFFFF},
    '{3'd4, 24'h000000, 24'h000000}
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic feed();
    wr(3'd2, 24'h0000AA);
    wr(3'd2, 24'h000055);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    wd_tick = 1'b1;
    repeat (n) @(negedge clk);
    wd_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, rv); check("R1 ctrl", rv, 24'h0);
    rd(3'd1, rv); check("R1 tcon", rv, 24'hFF);
    rd(3'd3, rv); check("R1 count", rv, 24'hFF);
    rd(3'd4, rv); check("R1 warn", rv, 24'h0);
    rd(3'd5, rv); check("R1 window", rv, 24'hFFFFFF);
    check("R1 outputs", {20'h0, clk_sel, wdt_reset_req, wdt_irq, warn_irq}, 24'h0);

    // R2 table of register writes and read-backs
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d);
      rd(VEC[i].a, rv);
      check("R2 reg table", rv, VEC[i].e);
    end

    // R11 clock select
    wr(3'd0, 24'h10);
    check("R11 clk_sel high", {23'h0, clk_sel}, 24'h1);
    wr(3'd0, 24'h00);
    check("R11 clk_sel low", {23'h0, clk_sel}, 24'h0);

    // R3 feed reload and prescaled count-down
    wr(3'd1, 24'h100);
    wr(3'd0, 24'h01);
    feed();
    rd(3'd3, rv); check("R3 reload", rv, 24'h100);
    ticks(40);
    rd(3'd3, rv); check("R3 count after 40 strobes", rv, 24'hF6);

    // R4 enable cannot be cleared
    wr(3'd0, 24'h00);
    rd(3'd0, rv); check("R4 enable sticky", rv, 24'h01);

    // R9 warning at count 0xF0
    wr(3'd4, 24'hF0);
    ticks(23);
    check("R9 no warn early", {23'h0, warn_irq}, 24'h0);
    ticks(1);
    check("R9 warn raised", {23'h0, warn_irq}, 24'h1);
    rd(3'd0, rv); check("R9 ctrl warn bit", rv, 24'h09);
    wr(3'd0, 24'h08);
    check("R9 warn cleared", {23'h0, warn_irq}, 24'h0);
    wr(3'd4, 24'h0);

    // R7 broken sequence: open key then a read
    wr(3'd2, 24'hAA);
    rd(3'd0, rv);
    check("R7 irq on broken feed", {23'h0, wdt_irq}, 24'h1);
    rd(3'd0, rv); check("R6 ctrl after fault", rv, 24'h20);
    wr(3'd0, 24'h20);
    check("R6 irq cleared", {23'h0, wdt_irq}, 24'h0);
    // R7 lone second key
    wr(3'd0, 24'h01);
    wr(3'd2, 24'h55);
    check("R7 irq on lone key", {23'h0, wdt_irq}, 24'h1);
    wr(3'd0, 24'h20);

    // R8 window
    wr(3'd1, 24'h100);
    wr(3'd5, 24'h80);
    feed();
    wr(3'd0, 24'h01);
    feed();
    check("R8 early feed faults", {23'h0, wdt_irq}, 24'h1);
    rd(3'd0, rv); check("R8 enable dropped", rv, 24'h20);
    wr(3'd0, 24'h20);
    wr(3'd0, 24'h01);
    ticks(512);
    rd(3'd3, rv); check("R8 count at window", rv, 24'h80);
    feed();
    rd(3'd3, rv); check("R8 feed in window reloads", rv, 24'h100);
    check("R8 no fault in window", {23'h0, wdt_irq}, 24'h0);

    // R5 time-out in reset mode
    wr(3'd1, 24'hFF);
    wr(3'd5, 24'hFFFFFF);
    wr(3'd0, 24'h03);
    feed();
    ticks(1023);
    check("R5 no request early", {23'h0, wdt_reset_req}, 24'h0);
    ticks(1);
    check("R5 request raised", {23'h0, wdt_reset_req}, 24'h1);
    @(negedge clk);
    check("R5 request one cycle", {23'h0, wdt_reset_req}, 24'h0);
    rd(3'd0, rv); check("R5 ctrl flag only", rv, 24'h04);
    rd(3'd1, rv); check("R5 tcon default", rv, 24'hFF);
    rd(3'd3, rv); check("R5 count default", rv, 24'hFF);

    // R10 flag persistence and clearing
    wr(3'd0, 24'h04);
    rd(3'd0, rv); check("R10 flag kept", rv, 24'h04);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(3'd0, rv); check("R10 POR clears flag", rv, 24'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule